// File: doc/BRIEF.md
# Programmable Symmetric Baud Timer

This block divides one of several clock-enable sources into a symmetrical square wave. Serial receivers and transmitters use that wave as a clock at sixteen times the bit rate. Every source arrives as a single-cycle enable pulse in the system-clock domain, and at most one pulse comes per cycle. The host loads a 16-bit reload value `n` as two separate byte writes. A control write then picks the source and starts or stops the timer.

While the timer runs, a down-counter is loaded with `n` and steps once for each pulse of the selected source. When the counter reaches zero, the output flips level and the counter reloads. Each half of the wave therefore lasts `n+1` source pulses, and the output frequency is the source rate divided by `2(n+1)`. This gives `n = f_src / (2 * 16 * baud) - 1` for the sixteen-times clock. Values 0 and 1 are both valid. A one-cycle `baudTick` marks every rising edge of the output, so a consumer can treat it as its enable.

Top module: `sym_baud_timer`

## Requirements
- R1: After reset the output `baudOut` and `baudTick` are low and the timer is stopped, so source pulses do not change the output.
- R2: Host writes are decoded by `wrAddr`:
  - 0 is the control register: bits [2:0] are the source select, bit 4 is run and bit 5 is stop. Stop takes priority when both are set.
  - 1 holds the upper reload byte.
  - 2 holds the lower reload byte.
  - 3 is ignored.
- R3: A control write with run set and stop clear loads the counter from the reload value. It drives `baudOut` high in the cycle after the write.
- R4: While running, each half of the output lasts exactly `n+1` pulses of the selected source, giving a full period of `2(n+1)` pulses.
- R5: Reload values 0 and 1 are legal and give periods of 2 and 4 source pulses.
- R6: The reload value spans 16 bits, and the upper byte contributes `256 * upper` to `n`.
- R7: Pulses on sources other than the selected one have no effect on the output.
- R8: A stop write freezes `baudOut` at its current level. While stopped, no pulse changes it and `baudTick` stays low.
- R9: A reload value written while running takes effect only at the next terminal count. The half-period in progress completes with the old value.
- R10: `baudTick` is high for exactly one cycle, in the same cycle that `baudOut` first shows a rising edge. This includes a start from low. It is never high at any other time, including a restart while the output is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | 2 | Host register address |
| wrData | input | 8 | Host write data |
| srcTick | input | NUM_SRC | Source clock-enable pulses, at most one per cycle |
| baudOut | output | 1 | Symmetrical square-wave output |
| baudTick | output | 1 | One-cycle pulse on each rising edge of `baudOut` |

## Verification
The bench builds the block with its defaults: a 16-bit counter and eight sources. With these values the upper reload byte is exercised by a value above 255, and every select code from 0 to 7 is within reach. The bench also covers the smallest reload values, a reload rewritten mid-half-period, stop at each output level, and conflicting run and stop bits. These are the places where an off-by-one in the half-period count or a misplaced priority would show.

// File: rtl/sym_baud_pkg.sv
package sym_baud_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_HI   = 2'd1,
    REG_LO   = 2'd2,
    REG_NONE = 2'd3
  } regSel_e;

  localparam int RUN_BIT  = 4;
  localparam int STOP_BIT = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic start;
    logic step;
  } dpStrobe_t;

endpackage

// File: rtl/sym_baud_ctrl.sv
module sym_baud_ctrl
  import sym_baud_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrAddr,
  input  logic [SEL_W-1:0]   selIn,
  input  logic               runIn,
  input  logic               stopIn,
  input  logic [NUM_SRC-1:0] srcTick,
  output dpStrobe_t          strobe,
  output logic               running
);

  logic [SEL_W-1:0] srcSel;
  logic             ctrlWr;
  logic             runReq;
  logic             stopReq;
  logic             selTick;

  assign ctrlWr  = wrEn && (wrAddr == REG_CTRL);
  assign stopReq = ctrlWr && stopIn;
  assign runReq  = ctrlWr && runIn && !stopIn;
  assign selTick = srcTick[srcSel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSel  <= '0;
      running <= 1'b0;
    end else begin
      if (ctrlWr) srcSel <= selIn;
      if (stopReq)     running <= 1'b0;
      else if (runReq) running <= 1'b1;
    end
  end

  always_comb begin
    strobe.loadHi = wrEn && (wrAddr == REG_HI);
    strobe.loadLo = wrEn && (wrAddr == REG_LO);
    strobe.start  = runReq;
    strobe.step   = running && selTick && !ctrlWr;
  end

endmodule

// File: rtl/sym_baud_dp.sv
module sym_baud_dp
  import sym_baud_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  input  logic [7:0] wrData,
  output logic      baudOut,
  output logic      baudTick
);

  localparam int HI_W = CNT_W - 8;

  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic             outNext;
  logic             atZero;

  assign atZero = (cnt == '0);

  always_comb begin
    cntNext = cnt;
    outNext = baudOut;
    if (strobe.start) begin
      cntNext = reloadVal;
      outNext = 1'b1;
    end else if (strobe.step) begin
      if (atZero) begin
        cntNext = reloadVal;
        outNext = !baudOut;
      end else begin
        cntNext = cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadVal <= '0;
      cnt       <= '0;
      baudOut   <= 1'b0;
      baudTick  <= 1'b0;
    end else begin
      if (strobe.loadHi) reloadVal[CNT_W-1:8] <= wrData[HI_W-1:0];
      if (strobe.loadLo) reloadVal[7:0]       <= wrData;
      cnt      <= cntNext;
      baudOut  <= outNext;
      baudTick <= outNext && !baudOut;
    end
  end

endmodule

// File: rtl/sym_baud_timer.sv
module sym_baud_timer
  import sym_baud_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrAddr,
  input  logic [7:0]         wrData,
  input  logic [NUM_SRC-1:0] srcTick,
  output logic               baudOut,
  output logic               baudTick
);

  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  dpStrobe_t strobe;
  logic      running;

  sym_baud_ctrl #(
    .NUM_SRC (NUM_SRC),
    .SEL_W   (SEL_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .selIn   (wrData[SEL_W-1:0]),
    .runIn   (wrData[RUN_BIT]),
    .stopIn  (wrData[STOP_BIT]),
    .srcTick (srcTick),
    .strobe  (strobe),
    .running (running)
  );

  sym_baud_dp #(
    .CNT_W (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .baudOut  (baudOut),
    .baudTick (baudTick)
  );

endmodule

// File: rtl/sym_baud_timer_chk.sv
module sym_baud_timer_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [1:0]         wrAddr,
  input logic [NUM_SRC-1:0] srcTick,
  input logic               baudOut,
  input logic               baudTick,
  input logic               running
);

  logic ctrlWr;
  assign ctrlWr = wrEn && (wrAddr == 2'd0);

  AST_TICK_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |-> (baudOut && !$past(baudOut))); // R10

  AST_RISE_GIVES_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(baudOut) |-> baudTick); // R10

  AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    $past(!running && !ctrlWr) |-> $stable(baudOut)); // R8

  AST_NO_SPONTANEOUS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(baudOut) |-> $past((|srcTick) || ctrlWr)); // R4

  AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !$past(ctrlWr)) |-> !baudTick); // R8

endmodule

bind sym_baud_timer sym_baud_timer_chk #(
  .NUM_SRC (NUM_SRC)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .srcTick  (srcTick),
  .baudOut  (baudOut),
  .baudTick (baudTick),
  .running  (running)
);

// File: tb/sym_baud_timer_tb.sv
module sym_baud_timer_tb;

  localparam int NUM_SRC = 8;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               wrEn = 1'b0;
  logic [1:0]         wrAddr = '0;
  logic [7:0]         wrData = '0;
  logic [NUM_SRC-1:0] srcTick = '0;
  logic               baudOut;
  logic               baudTick;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sym_baud_timer u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .srcTick  (srcTick),
    .baudOut  (baudOut),
    .baudTick (baudTick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // write at negedge, returns at the following negedge with the effect visible
  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = 2'd0; wrData = '0;
  endtask

  task automatic pulse(input int idx);
    srcTick = '0;
    srcTick[idx] = 1'b1;
    @(negedge clk);
    srcTick = '0;
  endtask

  // control field: sel bits [2:0], run bit 4, stop bit 5
  task automatic startTimer(input int n, input int sel);
    writeReg(2'd1, 8'((n >> 8) & 8'hFF));
    writeReg(2'd2, 8'(n & 8'hFF));
    writeReg(2'd0, 8'(sel | 8'h10));
  endtask

  task automatic stopTimer(input int sel);
    writeReg(2'd0, 8'(sel | 8'h20));
  endtask

  // counts selected pulses until the output changes
  task automatic measureHalf(input int idx, input int expCount, input string req);
    logic startLvl;
    int   cnt;
    bit   badTick;
    startLvl = baudOut;
    cnt = 0;
    badTick = 1'b0;
    do begin
      pulse(idx);
      cnt++;
      if (baudOut == startLvl && baudTick) badTick = 1'b1;
    end while (baudOut == startLvl && cnt < 70000);
    check(cnt == expCount, req, cnt, expCount);
    check(!badTick && (baudTick == baudOut), "R10", int'(baudTick), int'(baudOut));
  endtask

  task automatic tReset();
    check(baudOut == 1'b0, "R1", int'(baudOut), 0);
    check(baudTick == 1'b0, "R1", int'(baudTick), 0);
    for (int i = 0; i < 3; i++) pulse(0);
    check(baudOut == 1'b0, "R1", int'(baudOut), 0);
  endtask

  task automatic tStartN5();
    startTimer(5, 2);
    check(baudOut == 1'b1, "R3", int'(baudOut), 1);
    check(baudTick == 1'b1, "R10", int'(baudTick), 1);
    @(negedge clk);
    check(baudTick == 1'b0, "R10", int'(baudTick), 0);
    measureHalf(2, 6, "R4");
    measureHalf(2, 6, "R4");
    measureHalf(2, 6, "R4");
    stopTimer(2);
  endtask

  task automatic tMinimum();
    startTimer(0, 0);
    check(baudOut == 1'b1, "R3", int'(baudOut), 1);
    measureHalf(0, 1, "R5");
    measureHalf(0, 1, "R5");
    startTimer(1, 7);
    check(baudOut == 1'b1, "R3", int'(baudOut), 1);
    measureHalf(7, 2, "R5");
    measureHalf(7, 2, "R5");
    stopTimer(7);
  endtask

  task automatic tWide();
    startTimer(16'h0103, 3);
    measureHalf(3, 260, "R6");
    measureHalf(3, 260, "R6");
    stopTimer(3);
  endtask

  task automatic tSelect();
    logic lvl;
    startTimer(0, 4);
    lvl = baudOut;
    pulse(1); pulse(3); pulse(6); pulse(0);
    check(baudOut == lvl, "R7", int'(baudOut), int'(lvl));
    pulse(4);
    check(baudOut == !lvl, "R7", int'(baudOut), int'(!lvl));
    stopTimer(4);
  endtask

  task automatic tStop();
    bit sawTick;
    startTimer(2, 1);
    pulse(1);
    stopTimer(1);
    sawTick = 1'b0;
    for (int i = 0; i < 10; i++) begin
      pulse(1);
      if (baudTick) sawTick = 1'b1;
    end
    check(baudOut == 1'b1, "R8", int'(baudOut), 1);
    check(!sawTick, "R8", int'(sawTick), 0);
    startTimer(2, 1);
    for (int i = 0; i < 3; i++) pulse(1);
    check(baudOut == 1'b0, "R4", int'(baudOut), 0);
    stopTimer(1);
    for (int i = 0; i < 10; i++) pulse(1);
    check(baudOut == 1'b0, "R8", int'(baudOut), 0);
    // run and stop both set: stop wins
    writeReg(2'd0, 8'h31);
    check(baudOut == 1'b0, "R2", int'(baudOut), 0);
    for (int i = 0; i < 4; i++) pulse(1);
    check(baudOut == 1'b0, "R2", int'(baudOut), 0);
    // address 3 ignored
    writeReg(2'd3, 8'h11);
    pulse(1);
    check(baudOut == 1'b0, "R2", int'(baudOut), 0);
  endtask

  task automatic tReloadChange();
    startTimer(3, 0);
    pulse(0);
    writeReg(2'd2, 8'd1);
    measureHalf(0, 3, "R9");
    measureHalf(0, 2, "R9");
    measureHalf(0, 2, "R9");
    stopTimer(0);
  endtask

  task automatic tRestartHigh();
    startTimer(4, 5);
    @(negedge clk);
    check(baudOut == 1'b1, "R3", int'(baudOut), 1);
    writeReg(2'd0, 8'h15);
    check(baudOut == 1'b1, "R10", int'(baudOut), 1);
    check(baudTick == 1'b0, "R10", int'(baudTick), 0);
    measureHalf(5, 5, "R3");
    stopTimer(5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tStartN5();
    tMinimum();
    tWide();
    tSelect();
    tStop();
    tReloadChange();
    tRestartHigh();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule